// File: doc/BRIEF.md
# Programmable Refresh Interval Timer

This block paces the refresh traffic of a DRAM controller. It emits a one-cycle refresh strobe to the controller's command scheduler every N clock cycles. N is a 32-bit interval that a host CPU can rewrite while memory is in use. The count can run either as a down-counter that reloads when it reaches zero, or as an up-counter that clears when a greater-or-equal compare against the interval fires. Both forms give the same period. The counting form is chosen by a mode bit that is taken only together with an interval write.

Every write restarts the count and issues a refresh straight away, so a change of rate can never leave a row window uncovered. An interval of zero stops refresh generation altogether, which suits retention experiments. A request stays pending until the scheduler acknowledges it. Any expiry or write that finds a request still unacknowledged raises no new strobe. Instead it bumps a saturating missed-refresh counter that the host can read.

Top module: `refresh_pacer`

## Requirements
- R1: After reset, ref_strobe, ref_pending and missed_cnt are 0. The interval holds floor(CLK_HZ/1000 * WINDOW_MS / ROWS) cycles, which is 781 at 50 MHz with 64 ms and 4096 rows, and the mode is down-count. The first strobe appears exactly that many cycles after reset is released.
- R2: In down-count mode (cfg_mode = 0), with a nonzero interval N, ref_strobe pulses high for one cycle every N cycles.
- R3: In up-count mode (cfg_mode = 1), with a nonzero interval N, ref_strobe pulses every N cycles. The mode is taken only in a cycle with cfg_we high.
- R4: A write of a nonzero N (cfg_we high) produces a strobe in the cycle right after the write and restarts the count. The next strobe follows N cycles after that one.
- R5: The up-count expiry uses a greater-or-equal compare. Lowering the interval below the running count gives an expiry N cycles after the write, never a 32-bit rollover. The count never exceeds N-1.
- R6: After a write of zero, no strobe is issued, either in the following cycle or later, until the next nonzero write.
- R7: ref_pending rises with each strobe. It stays high until a cycle in which ref_ack is sampled high, and is low in the cycle after that.
- R8: A write or expiry that finds a request pending and not being acknowledged produces no strobe. It increments missed_cnt by one, and missed_cnt saturates at all ones.
- R9: A write or expiry in the same cycle as ref_ack on a pending request issues a new strobe and leaves missed_cnt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Host write strobe for interval and mode |
| cfg_mode | input | 1 | Counting form, taken on write: 0 down-count, 1 up-count |
| cfg_interval | input | IVL_W (32) | Refresh period in cycles; 0 disables refresh |
| ref_ack | input | 1 | Acknowledge from the command scheduler |
| ref_strobe | output | 1 | One-cycle refresh request pulse |
| ref_pending | output | 1 | A request is outstanding |
| missed_cnt | output | MISS_W (16) | Saturating count of refreshes dropped while pending |

## Verification
A corrupted count or interval register shows up at the ports as a wrong gap between strobes. This appears within one programmed period of the fault, and an equality compare that lets the count run past the interval would push the next strobe out by billions of cycles. A lost restart on a write shows up in the very next period, because the strobe after a write must come exactly N cycles later. A wrong pending or miss state shows up at once: a strobe appears while a request is still outstanding, or missed_cnt moves by something other than one step.

// File: rtl/refresh_pacer_pkg.sv
package refresh_pacer_pkg;

  typedef enum logic {
    CNT_DOWN = 1'b0,
    CNT_UP   = 1'b1
  } cnt_mode_e;

  // Cycles between row refreshes: whole retention window spread over all rows
  function automatic longint unsigned row_period(input longint unsigned clk_hz,
                                                 input longint unsigned window_ms,
                                                 input longint unsigned rows);
    return ((clk_hz / 1000) * window_ms) / rows;
  endfunction

endpackage

// File: rtl/rp_cfg_regs.sv
module rp_cfg_regs
  import refresh_pacer_pkg::*;
#(
  parameter int unsigned IVL_W   = 32,
  parameter logic [IVL_W-1:0] DEF_IVL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  cnt_mode_e        wr_mode,
  input  logic [IVL_W-1:0] wr_ivl,
  output logic [IVL_W-1:0] ivl_q,
  output cnt_mode_e        mode_q
);

  logic [IVL_W-1:0] ivl_d;
  cnt_mode_e        mode_d;
  logic             cfg_en;

  always_comb begin
    cfg_en = wr_en;
    ivl_d  = wr_ivl;
    mode_d = wr_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q  <= DEF_IVL;
      mode_q <= CNT_DOWN;
    end else if (cfg_en) begin
      ivl_q  <= ivl_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/rp_count_engine.sv
module rp_count_engine
  import refresh_pacer_pkg::*;
#(
  parameter int unsigned IVL_W   = 32,
  parameter logic [IVL_W-1:0] DEF_IVL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  cnt_mode_e        wr_mode,
  input  logic [IVL_W-1:0] wr_ivl,
  input  logic [IVL_W-1:0] ivl_q,
  input  cnt_mode_e        mode_q,
  output logic             expire,
  output logic [IVL_W-1:0] cnt_q
);

  localparam logic [IVL_W-1:0] ONE     = IVL_W'(1);
  localparam logic [IVL_W-1:0] CNT_RST = (DEF_IVL == '0) ? '0 : DEF_IVL - ONE;

  logic [IVL_W-1:0] cnt_d;
  logic [IVL_W-1:0] last_q;
  logic             live;
  logic             cnt_en;

  assign last_q = ivl_q - ONE;
  assign live   = (ivl_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    cnt_en = wr_en | live;
    if (wr_en) begin
      if (wr_mode == CNT_UP || wr_ivl == '0) cnt_d = '0;
      else                                   cnt_d = wr_ivl - ONE;
    end else if (live) begin
      if (mode_q == CNT_DOWN) begin
        if (cnt_q == '0) begin
          expire = 1'b1;
          cnt_d  = last_q;
        end else begin
          cnt_d  = cnt_q - ONE;
        end
      end else begin
        if (cnt_q >= last_q) begin
          expire = 1'b1;
          cnt_d  = '0;
        end else begin
          cnt_d  = cnt_q + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_RST;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rp_req_tracker.sv
module rp_req_tracker #(
  parameter int unsigned MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              ack,
  output logic              strobe_q,
  output logic              pending_q,
  output logic [MISS_W-1:0] missed_q
);

  logic              hold;
  logic              strobe_d;
  logic              pending_d;
  logic              miss_en;
  logic [MISS_W-1:0] missed_d;

  always_comb begin
    hold      = pending_q & ~ack;
    strobe_d  = issue & ~hold;
    pending_d = issue | hold;
    miss_en   = issue & hold & (missed_q != '1);
    missed_d  = missed_q + MISS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q  <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      strobe_q  <= strobe_d;
      pending_q <= pending_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       missed_q <= '0;
    else if (miss_en) missed_q <= missed_d;
  end

endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer
  import refresh_pacer_pkg::*;
#(
  parameter int unsigned IVL_W     = 32,
  parameter int unsigned MISS_W    = 16,
  parameter longint unsigned CLK_HZ    = 50_000_000,
  parameter longint unsigned WINDOW_MS = 64,
  parameter longint unsigned ROWS      = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_mode,
  input  logic [IVL_W-1:0]  cfg_interval,
  input  logic              ref_ack,
  output logic              ref_strobe,
  output logic              ref_pending,
  output logic [MISS_W-1:0] missed_cnt
);

  localparam logic [IVL_W-1:0] DEF_IVL = IVL_W'(row_period(CLK_HZ, WINDOW_MS, ROWS));

  cnt_mode_e        wr_mode;
  logic [IVL_W-1:0] ivl_q;
  cnt_mode_e        mode_q;
  logic [IVL_W-1:0] cnt_q;
  logic             expire;
  logic             issue;

  assign wr_mode = cnt_mode_e'(cfg_mode);
  assign issue   = (cfg_we && cfg_interval != '0) || expire;

  rp_cfg_regs #(.IVL_W(IVL_W), .DEF_IVL(DEF_IVL)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_mode (wr_mode),
    .wr_ivl  (cfg_interval),
    .ivl_q   (ivl_q),
    .mode_q  (mode_q)
  );

  rp_count_engine #(.IVL_W(IVL_W), .DEF_IVL(DEF_IVL)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_mode (wr_mode),
    .wr_ivl  (cfg_interval),
    .ivl_q   (ivl_q),
    .mode_q  (mode_q),
    .expire  (expire),
    .cnt_q   (cnt_q)
  );

  rp_req_tracker #(.MISS_W(MISS_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .ack       (ref_ack),
    .strobe_q  (ref_strobe),
    .pending_q (ref_pending),
    .missed_q  (missed_cnt)
  );

endmodule

// File: rtl/rp_checker.sv
module rp_checker #(
  parameter int unsigned IVL_W  = 32,
  parameter int unsigned MISS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [IVL_W-1:0]  cfg_interval,
  input logic              ref_ack,
  input logic              ref_strobe,
  input logic              ref_pending,
  input logic [MISS_W-1:0] missed_cnt,
  input logic [IVL_W-1:0]  ivl_q,
  input logic              mode_q,
  input logic [IVL_W-1:0]  cnt_q
);

  p_write_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_interval != '0 && !(ref_pending && !ref_ack)) |=> ref_strobe);

  p_zero_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_interval == '0) |=> !ref_strobe);

  p_strobe_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_strobe |-> ref_pending);

  p_pending_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pending && !ref_ack) |=> ref_pending);

  p_miss_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(missed_cnt) |-> (missed_cnt == MISS_W'($past(missed_cnt) + 1'b1)));

  p_miss_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(missed_cnt) |-> !ref_strobe);

  p_count_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ivl_q != '0) |-> (cnt_q <= ivl_q - IVL_W'(1)));

  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(mode_q));

endmodule

bind refresh_pacer rp_checker #(.IVL_W(IVL_W), .MISS_W(MISS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_interval (cfg_interval),
  .ref_ack      (ref_ack),
  .ref_strobe   (ref_strobe),
  .ref_pending  (ref_pending),
  .missed_cnt   (missed_cnt),
  .ivl_q        (ivl_q),
  .mode_q       (mode_q),
  .cnt_q        (cnt_q)
);

// File: tb/test_refresh_pacer.sv
`timescale 1ns/1ps
module test_refresh_pacer;

  localparam int unsigned MISS_W = 4;
  localparam int          DEF_N  = 50_000 * 64 / 4096;  // 781 cycles at 50 MHz

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic              cfg_mode = 1'b0;
  logic [31:0]       cfg_interval = '0;
  logic              ref_ack;
  logic              ref_strobe;
  logic              ref_pending;
  logic [MISS_W-1:0] missed_cnt;

  logic auto_ack = 1'b1;
  logic ack_auto_q = 1'b0;
  logic man_ack = 1'b0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) ack_auto_q <= ref_pending;
  assign ref_ack = auto_ack ? ack_auto_q : man_ack;

  refresh_pacer #(.MISS_W(MISS_W)) i_refresh_pacer (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_mode     (cfg_mode),
    .cfg_interval (cfg_interval),
    .ref_ack      (ref_ack),
    .ref_strobe   (ref_strobe),
    .ref_pending  (ref_pending),
    .missed_cnt   (missed_cnt)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_gap(input int n);
    return n;  // both counting forms repeat every n cycles
  endfunction

  task automatic do_write(input bit mode, input int n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = mode; cfg_interval = 32'(n);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic gap(output int g);
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!ref_strobe && g < 3000);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int g;
    void'($urandom(32'h5EED));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and default period
    chk(ref_strobe == 0, "R1 strobe after reset", ref_strobe, 0);
    chk(ref_pending == 0, "R1 pending after reset", ref_pending, 0);
    chk(missed_cnt == 0, "R1 missed after reset", missed_cnt, 0);
    gap(g);
    chk(g == DEF_N, "R1 first gap", g, DEF_N);

    // R2 / R4 directed down mode
    do_write(1'b0, 7);
    chk(ref_strobe == 1, "R4 strobe after write", ref_strobe, 1);
    for (int k = 0; k < 2; k++) begin
      gap(g); chk(g == exp_gap(7), "R2 down gap", g, 7);
    end
    // R3 directed up mode
    do_write(1'b1, 9);
    chk(ref_strobe == 1, "R4 strobe after write", ref_strobe, 1);
    for (int k = 0; k < 2; k++) begin
      gap(g); chk(g == exp_gap(9), "R3 up gap", g, 9);
    end

    // Random intervals and modes
    for (int it = 0; it < 14; it++) begin
      int n;
      bit m;
      n = int'($urandom_range(1, 40));
      m = 1'($urandom_range(0, 1));
      do_write(m, n);
      chk(ref_strobe == 1, "R4 strobe after random write", ref_strobe, 1);
      for (int k = 0; k < 2; k++) begin
        gap(g);
        chk(g == exp_gap(n), m ? "R3 random up gap" : "R2 random down gap", g, n);
      end
    end

    // R5 lowering interval below the running count
    do_write(1'b1, 60);
    repeat (40) @(negedge clk);
    do_write(1'b1, 10);
    chk(ref_strobe == 1, "R5 strobe on lowered write", ref_strobe, 1);
    gap(g); chk(g == 10, "R5 up gap after lowering", g, 10);
    do_write(1'b0, 60);
    repeat (40) @(negedge clk);
    do_write(1'b0, 10);
    gap(g); chk(g == 10, "R5 down gap after lowering", g, 10);

    // R6 zero interval disables refresh
    do_write(1'b0, 0);
    chk(ref_strobe == 0, "R6 no strobe on zero write", ref_strobe, 0);
    begin
      int seen = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (ref_strobe) seen++;
      end
      chk(seen == 0, "R6 strobes while disabled", seen, 0);
      chk(ref_pending == 0, "R6 pending while disabled", ref_pending, 0);
    end

    // R7 / R8 pending held without acknowledge, misses counted
    auto_ack = 1'b0; man_ack = 1'b0;
    do_write(1'b0, 5);
    chk(ref_strobe == 1, "R4 strobe before miss test", ref_strobe, 1);
    chk(ref_pending == 1, "R7 pending after strobe", ref_pending, 1);
    repeat (5) @(negedge clk);
    chk(ref_strobe == 0, "R8 no strobe on missed expiry", ref_strobe, 0);
    chk(missed_cnt == 1, "R8 missed after one expiry", missed_cnt, 1);
    chk(ref_pending == 1, "R7 pending held", ref_pending, 1);
    repeat (5) @(negedge clk);
    chk(missed_cnt == 2, "R8 missed after two expiries", missed_cnt, 2);
    @(negedge clk);
    man_ack = 1'b1;
    @(negedge clk);
    man_ack = 1'b0;
    chk(ref_pending == 0, "R7 pending cleared by ack", ref_pending, 0);
    // saturation
    do_write(1'b1, 1);
    repeat (25) @(negedge clk);
    chk(missed_cnt == 15, "R8 missed saturates", missed_cnt, 15);
    chk(ref_strobe == 0, "R8 no strobe while saturated", ref_strobe, 0);

    // R9 acknowledge coinciding with issue
    do_reset();
    auto_ack = 1'b1;
    do_write(1'b0, 1);
    begin
      int hi = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (ref_strobe) hi++;
      end
      chk(hi == 20, "R9 strobe every cycle with ack", hi, 20);
      chk(missed_cnt == 0, "R9 no misses with ack", missed_cnt, 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule